// File: doc/BRIEF.md
# Register-Controlled MDIO Management Master with Background Status Scan

This block drives a Clause-22 MDIO management bus (MDC clock and a bidirectional MDIO data line) from two 32-bit registers on a simple CPU register bus. Software writes one command word that carries an access flag, a start flag, a read or write opcode, a PHY address, a register number and 16 bits of write data. The block then runs one management frame. Bit 31 of the same register reads as busy until the frame has finished. After a read, bits 15:0 of that register hold the returned data.

A second register sets the MDC divide value and turns the preamble on or off. It also enables a background scanner. While the bus has no CPU work, the scanner reads a fixed PHY register from each PHY address in a contiguous range, one after another. Each poll result leaves the block on a one-cycle result strobe together with its address and data. A CPU command never interrupts a poll frame that has already begun. Once that frame ends, the CPU command goes next, ahead of the next poll.

Top module: `mdio_poll_master`

## Requirements
- R1: After reset, both registers read as zero, `mdc` is low, `mdioOe` is low and `pollValid` is low.
- R2: A write to register select 0 is accepted when bits 31 and 16 are both set and exactly one of bit 19 (read) or bit 18 (write) is set. Bit 31 of the readback is 1 from the cycle after acceptance until the frame has ended, and it is 0 afterwards.
- R3: After the optional preamble, each frame sends these fields, each MSB first: start bits 01; opcode 10 for a read or 01 for a write; the PHY address from command bits 24:20; the register number from bits 29:25; for a write, turnaround 10 followed by data bits 15:0.
- R4: When configuration bit 30 is 1, every frame starts with 32 ones. When it is 0, no preamble is sent.
- R5: The MDC period is 2*D system clocks, where D is configuration bits 29:24 and a value of 0 counts as 1. `mdioOut` changes only while MDC falls, never while MDC is high.
- R6: In a read frame, `mdioOe` is low for the two turnaround bits and the 16 data bits. Data is taken from `mdioIn` at each MDC rising edge, and it appears in command readback bits 15:0 once busy has cleared.
- R7: A command write is ignored when busy is set, when bit 16 or bit 31 is clear, or when bits 19 and 18 are equal. An ignored write starts no frame and leaves the command readback unchanged.
- R8: With configuration bit 31 set, the block reads PHY register 1 at addresses from the first-address field (bits 4:0) up to the last-address field (bits 12:8), in ascending order, and then wraps back to the first address. If the first address is not below the last, only the first address is polled. Each result comes out as a one-cycle `pollValid` with `pollAddr` and `pollData`. Clearing bit 31 stops new polls.
- R9: A CPU command accepted during a poll frame waits for that frame to end. The CPU frame is then the next frame on the bus, ahead of any further poll.
- R10: When autopoll goes from disabled to enabled, the scan restarts at the first address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| regWrEn | input | 1 | Register write strobe |
| regSel | input | 1 | Register select: 0 command, 1 configuration (write and read) |
| regWdata | input | 32 | Register write data |
| regRdata | output | 32 | Readback of the selected register |
| mdc | output | 1 | Management clock |
| mdioOut | output | 1 | MDIO value driven by the block |
| mdioOe | output | 1 | MDIO output enable |
| mdioIn | input | 1 | MDIO value seen on the pin |
| pollValid | output | 1 | One-cycle strobe for a finished poll |
| pollAddr | output | 5 | PHY address of the finished poll |
| pollData | output | 16 | Data returned by the finished poll |

## Verification
The bench connects a PHY model that decodes every frame from the MDC rising edges and answers reads with data derived from the address and register. Against that model it checks the following corner cases:

- **Turnaround timing.** A design that releases MDIO one bit late during a read would drive into the turnaround. A design that samples on the falling edge would return shifted data.
- **Busy window.** A design that lets a second command in during the busy window would run an extra frame or corrupt the pending fields.
- **Malformed commands.** A command without the start bit, or with both opcode bits set, must not start a frame.
- **Divide and range ends.** A divide value of zero, a single-address scan and a reversed range each trip designs that count off by one or never wrap.
- **Arbitration.** A CPU command is placed in the middle of a poll frame. A design that cuts the poll short, or lets another poll run first, shows up in the recorded frame order.

// File: rtl/mdio_pkg.sv
package mdio_pkg;
  localparam int ADDR_W = 5;
  localparam int DATA_W = 16;
  localparam int DIV_W  = 6;

  typedef struct packed {
    logic              launch;
    logic              isRead;
    logic              usePre;
    logic [ADDR_W-1:0] phy;
    logic [ADDR_W-1:0] regNum;
    logic [DATA_W-1:0] wrData;
    logic [DIV_W-1:0]  halfDiv;
  } frameReq_t;
endpackage

// File: rtl/mdio_datapath.sv
module mdio_datapath
  import mdio_pkg::*;
#(
  parameter int PRE_BITS = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  frameReq_t         req,
  input  logic              mdioIn,
  output logic              mdc,
  output logic              mdioOut,
  output logic              mdioOe,
  output logic              active,
  output logic              done,
  output logic [DATA_W-1:0] rdData
);
  localparam int HDR_BITS   = 4 + 2 * ADDR_W;
  localparam int FRAME_BITS = HDR_BITS + 2 + DATA_W;
  localparam int TOTAL      = PRE_BITS + FRAME_BITS;
  localparam int CNT_W      = $clog2(TOTAL + 1);
  localparam int TA_DATA    = 2 + DATA_W;

  logic [TOTAL-1:0]      shiftR;
  logic [CNT_W-1:0]      bitsLeft;
  logic [DIV_W-1:0]      divCnt, halfR, lastCnt;
  logic                  readR, mdcR, activeR, doneR;
  logic [DATA_W-1:0]     rdShift;
  logic [FRAME_BITS-1:0] frameBits;
  logic [TOTAL-1:0]      loadBits;

  always_comb begin
    frameBits = {2'b01, (req.isRead ? 2'b10 : 2'b01), req.phy, req.regNum,
                 (req.isRead ? 2'b00 : 2'b10),
                 (req.isRead ? {DATA_W{1'b0}} : req.wrData)};
    loadBits  = req.usePre ? {{PRE_BITS{1'b1}}, frameBits}
                           : {frameBits, {PRE_BITS{1'b0}}};
    lastCnt   = halfR - 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      shiftR   <= '0;
      bitsLeft <= '0;
      divCnt   <= '0;
      halfR    <= DIV_W'(1);
      readR    <= 1'b0;
      mdcR     <= 1'b0;
      activeR  <= 1'b0;
      doneR    <= 1'b0;
      rdShift  <= '0;
    end else begin
      doneR <= 1'b0;
      if (!activeR) begin
        if (req.launch) begin
          activeR  <= 1'b1;
          shiftR   <= loadBits;
          bitsLeft <= req.usePre ? CNT_W'(TOTAL) : CNT_W'(FRAME_BITS);
          halfR    <= (req.halfDiv == '0) ? DIV_W'(1) : req.halfDiv;
          readR    <= req.isRead;
          divCnt   <= '0;
          mdcR     <= 1'b0;
          rdShift  <= '0;
        end
      end else if (divCnt != lastCnt) begin
        divCnt <= divCnt + 1'b1;
      end else begin
        divCnt <= '0;
        mdcR   <= !mdcR;
        if (!mdcR) begin
          if (readR && bitsLeft <= CNT_W'(DATA_W))
            rdShift <= {rdShift[DATA_W-2:0], mdioIn};
        end else if (bitsLeft == CNT_W'(1)) begin
          activeR <= 1'b0;
          doneR   <= 1'b1;
        end else begin
          bitsLeft <= bitsLeft - 1'b1;
          shiftR   <= {shiftR[TOTAL-2:0], 1'b0};
        end
      end
    end
  end

  assign mdc     = mdcR;
  assign mdioOut = activeR ? shiftR[TOTAL-1] : 1'b1;
  assign mdioOe  = activeR && !(readR && bitsLeft <= CNT_W'(TA_DATA));
  assign active  = activeR;
  assign done    = doneR;
  assign rdData  = rdShift;

  assert_done_single_R2: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);
  assert_mdc_hold_R5: assert property (@(posedge clk) disable iff (!rstN)
    activeR && $past(activeR) && divCnt != '0 |-> $stable(mdc));
  assert_out_steady_high_R5: assert property (@(posedge clk) disable iff (!rstN)
    activeR && $past(activeR) && mdc && $past(mdc) |-> $stable(mdioOut));
endmodule

// File: rtl/mdio_ctrl.sv
module mdio_ctrl
  import mdio_pkg::*;
#(
  parameter int POLL_REG = 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWrEn,
  input  logic              regSel,
  input  logic [31:0]       regWdata,
  input  logic              dpActive,
  input  logic              dpDone,
  input  logic [DATA_W-1:0] dpRdData,
  output frameReq_t         req,
  output logic [31:0]       cmdWord,
  output logic [31:0]       cfgWord,
  output logic              pollValid,
  output logic [ADDR_W-1:0] pollAddr,
  output logic [DATA_W-1:0] pollData
);
  logic              cmdBusy, cmdPending, cmdRd, cmdWr;
  logic [ADDR_W-1:0] cmdPhy, cmdReg;
  logic [DATA_W-1:0] cmdData;
  logic              cfgEn, cfgPre;
  logic [DIV_W-1:0]  cfgDiv;
  logic [ADDR_W-1:0] cfgFirst, cfgLast, pollCur, frameAddr;
  logic              frameRun, ownerCpu;
  logic              wrCmd, wrCfg, cmdOk, launch, pickCpu;
  logic              unusedBit;

  assign unusedBit = regWdata[17];
  assign wrCmd   = regWrEn && !regSel;
  assign wrCfg   = regWrEn && regSel;
  assign cmdOk   = wrCmd && !cmdBusy && regWdata[31] && regWdata[16] &&
                   (regWdata[19] ^ regWdata[18]);
  assign pickCpu = cmdPending;
  assign launch  = !frameRun && (cmdPending || cfgEn);

  always_comb begin
    req.launch  = launch;
    req.isRead  = pickCpu ? cmdRd : 1'b1;
    req.usePre  = cfgPre;
    req.phy     = pickCpu ? cmdPhy : pollCur;
    req.regNum  = pickCpu ? cmdReg : ADDR_W'(POLL_REG);
    req.wrData  = cmdData;
    req.halfDiv = cfgDiv;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cmdBusy    <= 1'b0;
      cmdPending <= 1'b0;
      cmdRd      <= 1'b0;
      cmdWr      <= 1'b0;
      cmdPhy     <= '0;
      cmdReg     <= '0;
      cmdData    <= '0;
      cfgEn      <= 1'b0;
      cfgPre     <= 1'b0;
      cfgDiv     <= '0;
      cfgFirst   <= '0;
      cfgLast    <= '0;
      pollCur    <= '0;
      frameAddr  <= '0;
      frameRun   <= 1'b0;
      ownerCpu   <= 1'b0;
      pollValid  <= 1'b0;
      pollAddr   <= '0;
      pollData   <= '0;
    end else begin
      pollValid <= 1'b0;
      if (cmdOk) begin
        cmdBusy    <= 1'b1;
        cmdPending <= 1'b1;
        cmdRd      <= regWdata[19];
        cmdWr      <= regWdata[18];
        cmdReg     <= regWdata[29:25];
        cmdPhy     <= regWdata[24:20];
        cmdData    <= regWdata[DATA_W-1:0];
      end
      if (launch) begin
        frameRun  <= 1'b1;
        ownerCpu  <= pickCpu;
        frameAddr <= req.phy;
        if (pickCpu) cmdPending <= 1'b0;
      end
      if (dpDone) begin
        frameRun <= 1'b0;
        if (ownerCpu) begin
          cmdBusy <= 1'b0;
          if (cmdRd) cmdData <= dpRdData;
        end else begin
          pollValid <= 1'b1;
          pollAddr  <= frameAddr;
          pollData  <= dpRdData;
          pollCur   <= (frameAddr >= cfgLast) ? cfgFirst : frameAddr + 1'b1;
        end
      end
      if (wrCfg) begin
        cfgEn    <= regWdata[31];
        cfgPre   <= regWdata[30];
        cfgDiv   <= regWdata[29:24];
        cfgLast  <= regWdata[12:8];
        cfgFirst <= regWdata[4:0];
        if (regWdata[31] && !cfgEn) pollCur <= regWdata[4:0];
      end
    end
  end

  assign cmdWord = {cmdBusy, 1'b0, cmdReg, cmdPhy, cmdRd, cmdWr, 2'b00, cmdData};
  assign cfgWord = {cfgEn, cfgPre, cfgDiv, 11'b0, cfgLast, 3'b000, cfgFirst};

  assert_busy_hold_R2: assert property (@(posedge clk) disable iff (!rstN)
    cmdBusy && !dpDone |=> cmdBusy);
  assert_ignore_busy_R7: assert property (@(posedge clk) disable iff (!rstN)
    cmdBusy && wrCmd && !dpDone |=> cmdBusy && $stable(cmdPhy) && $stable(cmdReg));
  assert_launch_idle_R9: assert property (@(posedge clk) disable iff (!rstN)
    launch |-> !dpActive);
endmodule

// File: rtl/mdio_poll_master.sv
module mdio_poll_master
  import mdio_pkg::*;
#(
  parameter int PRE_BITS = 32,
  parameter int POLL_REG = 1
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        regWrEn,
  input  logic        regSel,
  input  logic [31:0] regWdata,
  output logic [31:0] regRdata,
  output logic        mdc,
  output logic        mdioOut,
  output logic        mdioOe,
  input  logic        mdioIn,
  output logic        pollValid,
  output logic [4:0]  pollAddr,
  output logic [15:0] pollData
);
  frameReq_t         req;
  logic              dpActive, dpDone;
  logic [DATA_W-1:0] dpRdData;
  logic [31:0]       cmdWord, cfgWord;

  mdio_ctrl #(.POLL_REG(POLL_REG)) u_ctrl (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regSel(regSel),
    .regWdata(regWdata), .dpActive(dpActive), .dpDone(dpDone),
    .dpRdData(dpRdData), .req(req), .cmdWord(cmdWord), .cfgWord(cfgWord),
    .pollValid(pollValid), .pollAddr(pollAddr), .pollData(pollData)
  );

  mdio_datapath #(.PRE_BITS(PRE_BITS)) u_dp (
    .clk(clk), .rstN(rstN), .req(req), .mdioIn(mdioIn), .mdc(mdc),
    .mdioOut(mdioOut), .mdioOe(mdioOe), .active(dpActive), .done(dpDone),
    .rdData(dpRdData)
  );

  assign regRdata = regSel ? cfgWord : cmdWord;
endmodule

// File: tb/mdio_poll_master_tb.sv
module mdio_poll_master_tb;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        regWrEn = 1'b0;
  logic        regSel = 1'b0;
  logic [31:0] regWdata = '0;
  logic [31:0] regRdata;
  logic        mdc, mdioOut, mdioOe;
  logic        mdioIn = 1'b1;
  logic        pollValid;
  logic [4:0]  pollAddr;
  logic [15:0] pollData;
  int total = 0, bad = 0;
  bit ended = 0;

  always #10 clk = !clk;

  mdio_poll_master u_dut (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regSel(regSel),
    .regWdata(regWdata), .regRdata(regRdata), .mdc(mdc), .mdioOut(mdioOut),
    .mdioOe(mdioOe), .mdioIn(mdioIn), .pollValid(pollValid),
    .pollAddr(pollAddr), .pollData(pollData)
  );

  function automatic logic [15:0] resp(input logic [4:0] p, input logic [4:0] r);
    return {3'b101, p, 3'b010, r};
  endfunction
  function automatic logic [31:0] mkCmd(input bit rd, input logic [4:0] p,
                                        input logic [4:0] r, input logic [15:0] d);
    return {1'b1, 1'b0, r, p, rd, !rd, 1'b0, 1'b1, d};
  endfunction
  function automatic logic [31:0] mkCfg(input bit en, input bit pre, input logic [5:0] dv,
                                        input logic [4:0] last, input logic [4:0] first);
    return {en, pre, dv, 11'b0, last, 3'b000, first};
  endfunction

  // PHY model: decodes frames on MDC rising edges, answers reads
  int k = 0, ones = 0, frameCount = 0;
  bit inFrame = 0;
  logic [31:0] word = '0, oeMask = '0;
  logic curRead = 1'b0;
  logic [4:0] curPhy = '0, curReg = '0;
  logic [4:0]  frPhy [0:255];
  logic [4:0]  frReg [0:255];
  logic [1:0]  frOp  [0:255];
  logic [1:0]  frTa  [0:255];
  logic [15:0] frData[0:255];
  logic [31:0] frOe  [0:255];
  int          frPre [0:255];

  always @(posedge mdc) begin
    if (!inFrame) begin
      if (mdioOe && mdioOut) ones++;
      else if (mdioOe && !mdioOut) begin
        inFrame = 1; k = 1; word = '0; oeMask = 32'h1;
      end
    end else begin
      word = {word[30:0], mdioOe ? mdioOut : 1'b0};
      oeMask = {oeMask[30:0], mdioOe};
      k++;
      if (k == 14) begin
        curRead = (word[11:10] == 2'b10); curPhy = word[9:5]; curReg = word[4:0];
      end
      if (k == 32) begin
        if (frameCount < 256) begin
          frOp[frameCount] = word[29:28]; frPhy[frameCount] = word[27:23];
          frReg[frameCount] = word[22:18]; frTa[frameCount] = word[17:16];
          frData[frameCount] = word[15:0]; frOe[frameCount] = oeMask;
          frPre[frameCount] = (word[30] == 1'b1) ? ones : -1;
        end
        frameCount++; inFrame = 0; ones = 0;
      end
    end
  end

  always @(negedge mdc) begin
    logic [15:0] rv;
    rv = resp(curPhy, curReg);
    if (inFrame && curRead && k >= 16 && k <= 31) mdioIn = rv[31-k];
    else mdioIn = 1'b1;
  end

  task automatic finishRun();
    if (!ended) begin
      ended = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  task automatic check(input bit ok, input string tag, input logic [31:0] act,
                       input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic regWrite(input bit sel, input logic [31:0] d);
    @(negedge clk); regSel = sel; regWdata = d; regWrEn = 1'b1;
    @(negedge clk); regWrEn = 1'b0;
  endtask

  task automatic regRead(input bit sel, output logic [31:0] d);
    @(negedge clk); regSel = sel; #1 d = regRdata;
  endtask

  task automatic waitIdle();
    logic [31:0] v;
    for (int i = 0; i < 4000; i++) begin
      regRead(0, v);
      if (!v[31]) return;
    end
    check(0, "R2 busy never cleared", 1, 0);
  endtask

  task automatic waitPoll(output logic [4:0] a, output logic [15:0] d);
    for (int i = 0; i < 4000; i++) begin
      @(negedge clk);
      if (pollValid) begin a = pollAddr; d = pollData; return; end
    end
    a = 'x; d = 'x;
    check(0, "R8 no poll result", 0, 1);
  endtask

  task automatic mdcPeriod(output int clks);
    longint t0, t1;
    @(posedge mdc); t0 = $time;
    @(posedge mdc); t1 = $time;
    clks = int'((t1 - t0) / 20);
  endtask

  task automatic testReset();
    logic [31:0] v;
    regRead(0, v); check(v == 0, "R1 cmd reg after reset", v, 0);
    regRead(1, v); check(v == 0, "R1 cfg reg after reset", v, 0);
    check(!mdioOe && !mdc && !pollValid, "R1 pins idle", {mdioOe, mdc, pollValid}, 0);
  endtask

  task automatic testWrite();
    logic [31:0] v; int n;
    n = frameCount;
    regWrite(0, mkCmd(0, 5'd5, 5'd3, 16'hBEEF));
    regRead(0, v); check(v[31] == 1'b1, "R2 busy set after write", v, 32'h80000000);
    waitIdle();
    check(frameCount == n + 1, "R3 one write frame", frameCount, n + 1);
    check(frOp[n] == 2'b01 && frPhy[n] == 5'd5 && frReg[n] == 5'd3,
          "R3 write header", {frOp[n], frPhy[n], frReg[n]}, {2'b01, 5'd5, 5'd3});
    check(frTa[n] == 2'b10 && frData[n] == 16'hBEEF, "R3 write ta and data",
          {frTa[n], frData[n]}, {2'b10, 16'hBEEF});
    check(frPre[n] == 0, "R4 no preamble", frPre[n], 0);
    check(frOe[n] == 32'hFFFFFFFF, "R3 write drives all bits", frOe[n], 32'hFFFFFFFF);
  endtask

  task automatic testPreamble();
    int n, p;
    regWrite(1, mkCfg(0, 1, 6'd3, 5'd0, 5'd0));
    n = frameCount;
    regWrite(0, mkCmd(0, 5'h1F, 5'h10, 16'h1234));
    mdcPeriod(p);
    check(p == 6, "R5 mdc period div 3", p, 6);
    waitIdle();
    check(frPre[n] == 32, "R4 preamble of 32 ones", frPre[n], 32);
    check(frPhy[n] == 5'h1F && frReg[n] == 5'h10 && frData[n] == 16'h1234,
          "R3 frame after preamble", {frPhy[n], frReg[n], frData[n]}, {5'h1F, 5'h10, 16'h1234});
  endtask

  task automatic testRead();
    logic [31:0] v; int n, p;
    regWrite(1, mkCfg(0, 0, 6'd0, 5'd0, 5'd0));
    n = frameCount;
    regWrite(0, mkCmd(1, 5'd9, 5'd17, 16'h0000));
    mdcPeriod(p);
    check(p == 2, "R5 mdc period with div 0", p, 2);
    waitIdle();
    regRead(0, v);
    check(v[15:0] == resp(5'd9, 5'd17), "R6 read data returned", v[15:0], resp(5'd9, 5'd17));
    check(frOp[n] == 2'b10, "R3 read opcode", frOp[n], 2'b10);
    check(frOe[n] == 32'hFFFC0000, "R6 released in turnaround and data", frOe[n], 32'hFFFC0000);
  endtask

  task automatic testIgnore();
    logic [31:0] v; int n;
    regWrite(1, mkCfg(0, 0, 6'd4, 5'd0, 5'd0));
    n = frameCount;
    regWrite(0, mkCmd(0, 5'd2, 5'd4, 16'h1111));
    regWrite(0, mkCmd(0, 5'd3, 5'd6, 16'h2222));
    waitIdle();
    repeat (100) @(negedge clk);
    check(frameCount == n + 1, "R7 write while busy ignored", frameCount, n + 1);
    check(frPhy[n] == 5'd2 && frData[n] == 16'h1111, "R7 first command kept",
          {frPhy[n], frData[n]}, {5'd2, 16'h1111});
    regRead(0, v);
    check(v[24:20] == 5'd2 && v[15:0] == 16'h1111, "R7 readback unchanged", v, 32'h00241111);
    n = frameCount;
    regWrite(0, mkCmd(0, 5'd7, 5'd1, 16'h3333) & ~32'h00010000);
    regRead(0, v); check(!v[31] && v[24:20] == 5'd2, "R7 no start bit ignored", v[31:20], 12'h002);
    regWrite(0, mkCmd(1, 5'd7, 5'd1, 16'h3333) | 32'h00040000);
    regRead(0, v); check(!v[31] && v[15:0] == 16'h1111, "R7 both opcodes ignored", v[15:0], 16'h1111);
    repeat (300) @(negedge clk);
    check(frameCount == n, "R7 no frame from bad commands", frameCount, n);
  endtask

  task automatic testPollRange();
    logic [4:0] a; logic [15:0] d; int n;
    logic [4:0] expSeq [0:4];
    expSeq[0] = 2; expSeq[1] = 3; expSeq[2] = 4; expSeq[3] = 2; expSeq[4] = 3;
    regWrite(1, mkCfg(1, 0, 6'd1, 5'd4, 5'd2));
    for (int i = 0; i < 5; i++) begin
      waitPoll(a, d);
      check(a == expSeq[i], "R8 scan order", a, expSeq[i]);
      check(d == resp(a, 5'd1), "R8 poll data", d, resp(a, 5'd1));
    end
    regWrite(1, mkCfg(0, 0, 6'd1, 5'd4, 5'd2));
    repeat (300) @(negedge clk);
    n = frameCount;
    repeat (300) @(negedge clk);
    check(frameCount == n, "R8 polling stops when disabled", frameCount, n);
  endtask

  task automatic testPollSingle();
    logic [4:0] a; logic [15:0] d;
    regWrite(1, mkCfg(1, 0, 6'd1, 5'd7, 5'd7));
    for (int i = 0; i < 3; i++) begin
      waitPoll(a, d); check(a == 5'd7, "R8 single address", a, 7);
    end
    regWrite(1, mkCfg(0, 0, 6'd1, 5'd4, 5'd9));
    repeat (200) @(negedge clk);
    regWrite(1, mkCfg(1, 0, 6'd1, 5'd4, 5'd9));
    for (int i = 0; i < 2; i++) begin
      waitPoll(a, d); check(a == 5'd9, "R8 reversed range polls first", a, 9);
    end
    regWrite(1, mkCfg(0, 0, 6'd1, 5'd8, 5'd6));
    repeat (200) @(negedge clk);
    regWrite(1, mkCfg(1, 0, 6'd1, 5'd8, 5'd6));
    waitPoll(a, d); check(a == 5'd6, "R10 restart at first address", a, 6);
    regWrite(1, mkCfg(0, 0, 6'd1, 5'd8, 5'd6));
    repeat (300) @(negedge clk);
  endtask

  task automatic testArbitrate();
    logic [4:0] a; logic [15:0] d; int n;
    regWrite(1, mkCfg(1, 0, 6'd1, 5'd3, 5'd1));
    waitPoll(a, d);
    repeat (10) @(negedge clk);
    n = frameCount;
    regWrite(0, mkCmd(0, 5'h1A, 5'd2, 16'hCAFE));
    waitIdle();
    check(frOp[n] == 2'b10 && frReg[n] == 5'd1, "R9 poll frame finished first",
          {frOp[n], frReg[n]}, {2'b10, 5'd1});
    check(frOp[n+1] == 2'b01 && frPhy[n+1] == 5'h1A && frData[n+1] == 16'hCAFE,
          "R9 cpu frame next", {frOp[n+1], frPhy[n+1], frData[n+1]}, {2'b01, 5'h1A, 16'hCAFE});
    waitPoll(a, d);
    waitPoll(a, d);
    check(d == resp(a, 5'd1), "R9 polling resumes", d, resp(a, 5'd1));
    regWrite(1, mkCfg(0, 0, 6'd1, 5'd3, 5'd1));
    repeat (300) @(negedge clk);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    check(0, "watchdog expired", 0, 1);
    finishRun();
  end

  initial begin
    repeat (5) @(negedge clk);
    rstN = 1'b1;
    testReset();
    testWrite();
    testPreamble();
    testRead();
    testIgnore();
    testPollRange();
    testPollSingle();
    testArbitrate();
    finishRun();
  end
endmodule